// File: doc/BRIEF.md
# Test-access instruction register and decoder

This block holds the three-bit instruction of a boundary-scan test port and turns it into the controls the rest of the test logic needs. A shift stage is loaded with a fixed pattern on capture and clocked from TDI toward TDO during instruction shifting; a separate parallel stage takes the shifted value on the falling test-clock edge while the controller sits in Update-IR, and is forced to the identification instruction whenever the controller is in Test-Logic-Reset. The TAP state machine lives outside and reports its current state through one-hot indication inputs.

Inside the block sit the one-bit bypass register and the 32-bit identification register. The boundary scan chain is outside; the block tells it when it is selected and takes its serial output back in. The decoded instruction also produces three pin-control outputs: drive pins from the boundary scan update latches, hold those pins frozen, or put every pin in high impedance. TDO is launched on the falling test-clock edge, and its enable is asserted only while shifting, so that the pad is high impedance in every other state.

Top module: `tap_instr_unit`

## Requirements
- R1: In Capture-IR the shift stage loads 3'b001; in Shift-IR every rising TCK edge moves it one place toward TDO, with TDI entering the most significant bit, so the captured bits leave TDO in the order 1, 0, 0.
- R2: The parallel stage changes only on a falling TCK edge in Update-IR, where it takes the shift stage value; Shift-IR and exit states without an update leave the pin controls and selected register unchanged.
- R3: Reset or Test-Logic-Reset forces the parallel stage to the identification opcode 3'b001.
- R4: Opcode map: 000 boundary-scan drive, 001 identification, 010 sample/preload, 011 clamp, 100 high impedance, 111 bypass; 101 and 110 behave exactly as 111.
- R5: When the bypass register is selected it loads 0 in Capture-DR, so TDO in Shift-DR gives 0 first and then each TDI bit one shift later.
- R6: When identification is selected, Capture-DR loads {version[3:0], part[15:0], maker[10:0], 1'b1}, shifted out least significant bit first with TDI filling the top.
- R7: Opcode 000 asserts pin_from_bsr and bsr_sel with pin_hold and pin_hiz low.
- R8: Opcode 011 asserts pin_from_bsr and pin_hold while the bypass register is on TDO and bsr_sel is low.
- R9: Opcode 100 asserts pin_hiz with pin_from_bsr low and the bypass register on TDO.
- R10: TDO data and tdo_oe update on the falling TCK edge; tdo_oe is 1 only after a falling edge in Shift-IR or Shift-DR.
- R11: Opcodes 000 and 010 assert bsr_sel and route bsr_so to TDO in Shift-DR; 010 leaves all pin controls low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| st_tlr | input | 1 | Controller is in Test-Logic-Reset |
| st_cap_ir | input | 1 | Controller is in Capture-IR |
| st_shift_ir | input | 1 | Controller is in Shift-IR |
| st_upd_ir | input | 1 | Controller is in Update-IR |
| st_cap_dr | input | 1 | Controller is in Capture-DR |
| st_shift_dr | input | 1 | Controller is in Shift-DR |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary scan chain |
| bsr_sel | output | 1 | Boundary scan chain is the selected data register |
| pin_from_bsr | output | 1 | Device pins take their values from the boundary scan update latches |
| pin_hold | output | 1 | Those pin values stay frozen |
| pin_hiz | output | 1 | All device outputs in high impedance |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | TDO drive enable; low means the pad is high impedance |

## Verification
The assertions watch on every cycle the capture pattern and shift motion of the instruction stage, the rule that the parallel stage moves only on an update and snaps to identification on reset, the bypass and identification capture values, the silence of TDO outside shift states and the mutual consistency of the pin controls. Only the bench scenarios show the full opcode map end to end: every one of the eight opcodes is shifted in, updated and then exercised through a data-register shift whose TDO stream is compared with the bypass delay, the identification word or the external chain, and an instruction shift that is not followed by an update is shown to leave the outputs alone.

// File: rtl/tap_instr_pkg.sv
package tap_instr_pkg;

  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_EXTEST = 3'b000;
  localparam logic [OPC_W-1:0] OPC_IDCODE = 3'b001;
  localparam logic [OPC_W-1:0] OPC_SAMPLE = 3'b010;
  localparam logic [OPC_W-1:0] OPC_CLAMP  = 3'b011;
  localparam logic [OPC_W-1:0] OPC_HIGHZ  = 3'b100;
  localparam logic [OPC_W-1:0] OPC_BYPASS = 3'b111;

  // value loaded into the shift stage on Capture-IR
  localparam logic [OPC_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0,
    DR_BSCAN  = 2'd1,
    DR_IDENT  = 2'd2
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;
    logic    from_bsr;
    logic    hold;
    logic    hiz;
  } instr_ctl_t;

  localparam instr_ctl_t CTL_IDENT = '{dr: DR_IDENT, from_bsr: 1'b0, hold: 1'b0, hiz: 1'b0};

endpackage

// File: rtl/instr_decode.sv
module instr_decode
  import tap_instr_pkg::*;
#(
  parameter int W = OPC_W
) (
  input  logic [W-1:0] opc,
  output instr_ctl_t   ctl
);

  always_comb begin
    ctl = '{dr: DR_BYPASS, from_bsr: 1'b0, hold: 1'b0, hiz: 1'b0};
    unique case (opc)
      OPC_EXTEST: begin
        ctl.dr       = DR_BSCAN;
        ctl.from_bsr = 1'b1;
      end
      OPC_IDCODE: ctl.dr = DR_IDENT;
      OPC_SAMPLE: ctl.dr = DR_BSCAN;
      OPC_CLAMP: begin
        ctl.from_bsr = 1'b1;
        ctl.hold     = 1'b1;
      end
      OPC_HIGHZ:  ctl.hiz = 1'b1;
      default:    ctl.dr = DR_BYPASS; // 111 and the unused 101/110
    endcase
  end

endmodule

// File: rtl/instr_stage.sv
module instr_stage
  import tap_instr_pkg::*;
#(
  parameter int              W       = OPC_W,
  parameter logic [W-1:0]    CAP_VAL = IR_CAPTURE,
  parameter logic [W-1:0]    RST_OPC = OPC_IDCODE
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         st_tlr,
  input  logic         st_cap_ir,
  input  logic         st_shift_ir,
  input  logic         st_upd_ir,
  input  logic         tdi,
  output logic         sr_lsb,
  output logic [W-1:0] opc_next,
  output logic [W-1:0] opc_q
);

  logic [W-1:0] sr;

  // shift stage, rising edge
  always_ff @(posedge tck) begin
    if (rst)              sr <= CAP_VAL;
    else if (st_cap_ir)   sr <= CAP_VAL;
    else if (st_shift_ir) sr <= {tdi, sr[W-1:1]};
  end

  always_comb begin
    opc_next = opc_q;
    if (rst || st_tlr)  opc_next = RST_OPC;
    else if (st_upd_ir) opc_next = sr;
  end

  // parallel stage, falling edge
  always_ff @(negedge tck) opc_q <= opc_next;

  assign sr_lsb = sr[0];

  // R1
  cap_pattern_chk: assert property (@(posedge tck) disable iff (rst)
    st_cap_ir |=> sr == CAP_VAL);
  // R1
  shift_move_chk: assert property (@(posedge tck) disable iff (rst)
    (st_shift_ir && !st_cap_ir) |=> sr == {$past(tdi), $past(sr[W-1:1])});
  // R3
  tlr_force_chk: assert property (@(negedge tck) disable iff (rst)
    st_tlr |=> opc_q == RST_OPC);
  // R2
  update_take_chk: assert property (@(negedge tck) disable iff (rst)
    (st_upd_ir && !st_tlr) |=> opc_q == $past(sr));
  // R2
  par_hold_chk: assert property (@(negedge tck) disable iff (rst)
    (!st_upd_ir && !st_tlr) |=> $stable(opc_q));

endmodule

// File: rtl/data_regs.sv
module data_regs
  import tap_instr_pkg::*;
#(
  parameter int               ID_W   = 32,
  parameter logic [ID_W-1:0]  ID_VAL = {{(ID_W-1){1'b0}}, 1'b1}
) (
  input  logic    tck,
  input  logic    rst,
  input  logic    st_cap_dr,
  input  logic    st_shift_dr,
  input  dr_sel_e sel,
  input  logic    tdi,
  output logic    byp_q,
  output logic    id_lsb
);

  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck) begin
    if (rst) byp_q <= 1'b0;
    else if (sel == DR_BYPASS) begin
      if (st_cap_dr)        byp_q <= 1'b0;
      else if (st_shift_dr) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) id_sr <= ID_VAL;
    else if (sel == DR_IDENT) begin
      if (st_cap_dr)        id_sr <= ID_VAL;
      else if (st_shift_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  assign id_lsb = id_sr[0];

  // R5
  byp_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (st_cap_dr && sel == DR_BYPASS) |=> !byp_q);
  // R6
  id_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (st_cap_dr && sel == DR_IDENT) |=> id_sr[0]);
  // R5
  byp_follow_chk: assert property (@(posedge tck) disable iff (rst)
    (st_shift_dr && !st_cap_dr && sel == DR_BYPASS) |=> byp_q == $past(tdi));

endmodule

// File: rtl/tdo_stage.sv
module tdo_stage (
  input  logic tck,
  input  logic rst,
  input  logic st_shift_ir,
  input  logic st_shift_dr,
  input  logic ir_bit,
  input  logic dr_bit,
  output logic tdo,
  output logic tdo_oe
);

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= st_shift_ir | st_shift_dr;
      tdo    <= st_shift_ir ? ir_bit : (st_shift_dr ? dr_bit : 1'b0);
    end
  end

  // R10
  tdo_quiet_chk: assert property (@(negedge tck) disable iff (rst)
    !(st_shift_ir || st_shift_dr) |=> !tdo_oe);
  // R10
  tdo_ir_chk: assert property (@(negedge tck) disable iff (rst)
    st_shift_ir |=> tdo_oe && tdo == $past(ir_bit));

endmodule

// File: rtl/tap_instr_unit.sv
module tap_instr_unit
  import tap_instr_pkg::*;
#(
  parameter int                MAKER_W = 11,
  parameter int                PART_W  = 16,
  parameter int                VER_W   = 4,
  parameter logic [MAKER_W-1:0] MAKER  = 11'h0A5,
  parameter logic [PART_W-1:0]  PART   = 16'h3C7E,
  parameter logic [VER_W-1:0]   VER    = 4'h2
) (
  input  logic tck,
  input  logic rst,
  input  logic st_tlr,
  input  logic st_cap_ir,
  input  logic st_shift_ir,
  input  logic st_upd_ir,
  input  logic st_cap_dr,
  input  logic st_shift_dr,
  input  logic tdi,
  input  logic bsr_so,
  output logic bsr_sel,
  output logic pin_from_bsr,
  output logic pin_hold,
  output logic pin_hiz,
  output logic tdo,
  output logic tdo_oe
);

  localparam int              ID_W   = 1 + MAKER_W + PART_W + VER_W;
  localparam logic [ID_W-1:0] ID_VAL = {VER, PART, MAKER, 1'b1};

  logic [OPC_W-1:0] opc_next, opc_q;
  logic             ir_bit, byp_q, id_lsb, dr_bit;
  instr_ctl_t       ctl_next, ctl_q;

  instr_stage #(.W(OPC_W), .CAP_VAL(IR_CAPTURE), .RST_OPC(OPC_IDCODE)) u_ir (
    .tck(tck), .rst(rst), .st_tlr(st_tlr), .st_cap_ir(st_cap_ir),
    .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir), .tdi(tdi),
    .sr_lsb(ir_bit), .opc_next(opc_next), .opc_q(opc_q)
  );

  instr_decode #(.W(OPC_W)) u_dec (.opc(opc_next), .ctl(ctl_next));

  // decoded controls registered alongside the parallel stage
  always_ff @(negedge tck) begin
    if (rst) ctl_q <= CTL_IDENT;
    else     ctl_q <= ctl_next;
  end

  data_regs #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .rst(rst), .st_cap_dr(st_cap_dr), .st_shift_dr(st_shift_dr),
    .sel(ctl_q.dr), .tdi(tdi), .byp_q(byp_q), .id_lsb(id_lsb)
  );

  always_comb begin
    unique case (ctl_q.dr)
      DR_BSCAN: dr_bit = bsr_so;
      DR_IDENT: dr_bit = id_lsb;
      default:  dr_bit = byp_q;
    endcase
  end

  tdo_stage u_tdo (
    .tck(tck), .rst(rst), .st_shift_ir(st_shift_ir), .st_shift_dr(st_shift_dr),
    .ir_bit(ir_bit), .dr_bit(dr_bit), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  assign bsr_sel      = (ctl_q.dr == DR_BSCAN);
  assign pin_from_bsr = ctl_q.from_bsr;
  assign pin_hold     = ctl_q.hold;
  assign pin_hiz      = ctl_q.hiz;

  // R9
  hiz_excl_chk: assert property (@(negedge tck) disable iff (rst)
    pin_hiz |-> !pin_from_bsr && !bsr_sel);
  // R8
  clamp_byp_chk: assert property (@(negedge tck) disable iff (rst)
    pin_hold |-> pin_from_bsr && !bsr_sel);
  // R4
  ctl_track_chk: assert property (@(negedge tck) disable iff (rst)
    (opc_q == OPC_IDCODE) |-> !bsr_sel && !pin_from_bsr && !pin_hiz);

endmodule

// File: tb/tap_instr_unit_tb.sv
module tap_instr_unit_tb;

  localparam logic [31:0] ID_EXP = {4'h2, 16'h3C7E, 11'h0A5, 1'b1};
  // state bits: {sdr, cdr, uir, sir, cir, tlr}
  localparam logic [5:0] S_IDLE = 6'b000000, S_TLR = 6'b000001, S_CIR = 6'b000010,
                         S_SIR = 6'b000100, S_UIR = 6'b001000, S_CDR = 6'b010000,
                         S_SDR = 6'b100000;

  logic tck = 1'b0, rst = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
  logic [5:0] st = S_IDLE;
  logic bsr_sel, pin_from_bsr, pin_hold, pin_hiz, tdo, tdo_oe;
  logic tdo_s, oe_s;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #4 tck = ~tck;

  tap_instr_unit u_dut (
    .tck(tck), .rst(rst), .st_tlr(st[0]), .st_cap_ir(st[1]), .st_shift_ir(st[2]),
    .st_upd_ir(st[3]), .st_cap_dr(st[4]), .st_shift_dr(st[5]), .tdi(tdi),
    .bsr_so(bsr_so), .bsr_sel(bsr_sel), .pin_from_bsr(pin_from_bsr),
    .pin_hold(pin_hold), .pin_hiz(pin_hiz), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one TCK period: inputs set after a rising edge, sampled after the falling edge
  task automatic step(input logic [5:0] s, input logic d, input logic b);
    st = s; tdi = d; bsr_so = b;
    @(negedge tck); #1;
    tdo_s = tdo; oe_s = tdo_oe;
    @(posedge tck); #1;
  endtask

  task automatic pins_chk(input string req, input logic [3:0] exp);
    chk({bsr_sel, pin_from_bsr, pin_hold, pin_hiz} == exp, req,
        {bsr_sel, pin_from_bsr, pin_hold, pin_hiz}, exp);
  endtask

  task automatic load_ir(input logic [2:0] op, input logic do_upd);
    logic [2:0] got;
    step(S_CIR, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(S_SIR, op[k], 1'b0);
      got[k] = tdo_s;
      chk(oe_s, "R10 oe in Shift-IR", oe_s, 1);
    end
    chk(got == 3'b001, "R1 captured IR pattern", got, 3'b001);
    step(do_upd ? S_UIR : S_IDLE, 1'b0, 1'b0);
    chk(!oe_s, "R10 oe off outside shift", oe_s, 0);
  endtask

  task automatic read_id(input string req);
    logic [31:0] got;
    step(S_CDR, 1'b0, 1'b0);
    for (int k = 0; k < 32; k++) begin
      step(S_SDR, 1'b0, 1'b0);
      got[k] = tdo_s;
    end
    chk(got == ID_EXP, req, got, ID_EXP);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(posedge tck); #1;
    rst = 1'b1;
    step(S_SIR, 1'b1, 1'b1);
    step(S_SDR, 1'b1, 1'b1);
    chk(!oe_s, "R10 oe low in reset", oe_s, 0);
    pins_chk("R3 reset pin controls", 4'b0000);
    rst = 1'b0;
    step(S_IDLE, 1'b0, 1'b0);
    read_id("R3 R6 ID after reset");

    for (int op = 0; op < 8; op++) begin
      logic [3:0] exp_pins;
      logic       is_bsr, is_id;
      logic [63:0] hist;
      is_bsr = (op == 0) || (op == 2);
      is_id  = (op == 1);
      // R4 R7 R8 R9 R11: {bsr_sel, from_bsr, hold, hiz}
      exp_pins = {is_bsr, (op == 0) || (op == 3), op == 3, op == 4};
      load_ir(3'(op), 1'b1);
      pins_chk($sformatf("R4 R7 R8 R9 R11 pins op %0d", op), exp_pins);

      step(S_CDR, 1'b0, 1'b0);
      for (int k = 0; k < 34; k++) begin
        logic d, b, e;
        d = ((k * 5 + op) % 7) < 3;
        b = ((k + op) % 3) == 0;
        hist[k] = d;
        step(S_SDR, d, b);
        if (is_bsr)     e = b;
        else if (is_id) e = (k < 32) ? ID_EXP[k] : hist[k-32];
        else            e = (k == 0) ? 1'b0 : hist[k-1];
        chk(tdo_s == e && oe_s,
            $sformatf("%s op %0d bit %0d", is_bsr ? "R11 chain" : (is_id ? "R6 ident" : "R5 bypass"), op, k),
            {oe_s, tdo_s}, {1'b1, e});
      end

      // shift a different opcode but leave without update
      load_ir(~3'(op), 1'b0);
      pins_chk($sformatf("R2 no update op %0d", op), exp_pins);

      step(S_TLR, 1'b0, 1'b0);
      pins_chk("R3 TLR pins", 4'b0000);
      step(S_IDLE, 1'b0, 1'b0);
      read_id($sformatf("R3 ID after TLR op %0d", op));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule